// File: doc/BRIEF.md
# DDR4 Power-Up Initialization Sequencer

This block is the controller-side sequencer that takes a DDR4 device from power-up to the idle state. After a start pulse it holds the device reset low, releases it, raises clock enable, and loads the seven mode registers in a fixed order. It then issues one long ZQ calibration command and waits out the calibration time before it raises a done flag. Every wait is a programmable cycle count on an input port, so one netlist serves several speed grades.

Commands leave on an abstract bus. It carries a command type, a mode register index and a 17-bit register value, with a one-cycle valid strobe. The register images are assembled from port fields: output drive strength, the three termination settings, the VrefDQ level and range, CAS latency and CAS write latency. Training and periodic calibration belong to other blocks, which start once the done flag is high.

Top module: `ddr4_init_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a start is accepted, `dram_reset_n`, `dram_cke`, `cmd_valid` and `init_done` are 0, `cmd_type` is 0 (no operation) and `cmd_value` is 0.
- R2: A start accepted at a clock edge drives `dram_reset_n` low from that edge for max(`t_reset`,1) cycles, and then drives it high.
- R3: `dram_cke` rises max(`t_cke`,1) cycles after `dram_reset_n` rises and stays high until the next accepted start.
- R4: The first mode register command comes max(`t_xpr`,1) cycles after `dram_cke` rises.
- R5: Mode register commands (`cmd_type` = 1) are issued in the register order 3, 6, 5, 4, 2, 1, 0, and `cmd_mr` carries the register number.
- R6: Consecutive commands, including the step from register 0 to the ZQ calibration command, lie exactly max(`t_mrd`,1) cycles apart. Each command holds `cmd_valid` high for one cycle. Between commands `cmd_valid` is 0 and `cmd_value` is 0.
- R7: Register images: reg 0 holds CL[3:1] in bits 6:4 and CL[0] in bit 2. Reg 1 holds DLL-enable 1 in bit 0, drive strength in bits 2:1 and nominal termination in bits 10:8. Reg 2 holds write latency in bits 5:3 and write termination in bits 11:9. Reg 5 holds park termination in bits 8:6. Reg 6 holds the VrefDQ value in bits 5:0 and the range in bit 6. Regs 3 and 4 are all zero, so the multi-purpose register access bit (reg 3 bit 2) stays 0. All other bits are 0.
- R8: The ZQ calibration command has `cmd_type` = 2, `cmd_mr` = 0 and value 0. `init_done` rises max(`t_zqinit`,1) cycles after it, then stays high with no further commands.
- R9: A start pulse is ignored from the first reset-hold cycle until `init_done` rises, so the sequence timing is unchanged.
- R10: A start while `init_done` is high restarts the sequence: `init_done` falls, and `dram_reset_n` and `dram_cke` go low at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart the sequence |
| t_reset | input | CNT_W | Reset hold time, cycles |
| t_cke | input | CNT_W | Reset release to clock enable, cycles |
| t_xpr | input | CNT_W | Clock enable to first register load, cycles |
| t_mrd | input | CNT_W | Command-to-command spacing, cycles |
| t_zqinit | input | CNT_W | ZQ calibration to done, cycles |
| drv_str | input | 2 | Output drive strength code |
| rtt_nom | input | 3 | Nominal termination code |
| rtt_wr | input | 3 | Write termination code |
| rtt_park | input | 3 | Park termination code |
| vref_val | input | 6 | VrefDQ level code |
| vref_rng | input | 1 | VrefDQ range select |
| cas_lat | input | 4 | CAS latency code |
| cas_wr_lat | input | 3 | CAS write latency code |
| dram_reset_n | output | 1 | Device reset, active low |
| dram_cke | output | 1 | Device clock enable |
| cmd_valid | output | 1 | Command strobe, one cycle per command |
| cmd_type | output | 2 | 0 none, 1 register load, 2 ZQ calibration |
| cmd_mr | output | 3 | Mode register number |
| cmd_value | output | 17 | Mode register image |
| init_done | output | 1 | Sequence complete, device idle |

## Verification
Each run draws the wait counts and all register fields at random from a fixed seed. Because every wait differs between runs, a swapped or miscounted interval shows up as a wrong measured distance. Directed runs set every count to zero or one, which checks the floor of one cycle and the back-to-back command path without a gap state. One run injects a start pulse in the middle of the sequence and must produce timings identical to a clean run. Back-to-back runs restart from the done state, which checks that the pins fall at once and that the second run uses fresh field values.

// File: rtl/ddr4_init_pkg.sv
package ddr4_init_pkg;

  localparam int NUM_MRS = 7;
  localparam int STEP_W  = 3;
  localparam int MRV_W   = 17;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_MRS  = 2'd1,
    CMD_ZQCL = 2'd2
  } cmd_e;

  typedef enum logic [3:0] {
    ST_OFF, ST_RST, ST_CKE, ST_XPR, ST_MRS, ST_GAP, ST_ZQ, ST_ZQW, ST_IDLE
  } st_e;

  typedef struct packed {
    logic [1:0] drv;
    logic [2:0] rtt_nom;
    logic [2:0] rtt_wr;
    logic [2:0] rtt_park;
    logic [5:0] vref;
    logic       vref_rng;
    logic [3:0] cl;
    logic [2:0] cwl;
  } mr_fields_t;

  // Load order: the register number issued at each step.
  function automatic logic [2:0] mr_at_step(input logic [STEP_W-1:0] s);
    case (s)
      3'd0:    mr_at_step = 3'd3;
      3'd1:    mr_at_step = 3'd6;
      3'd2:    mr_at_step = 3'd5;
      3'd3:    mr_at_step = 3'd4;
      3'd4:    mr_at_step = 3'd2;
      3'd5:    mr_at_step = 3'd1;
      default: mr_at_step = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ddr4_init_timer.sv
module ddr4_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2: a running count moves down by exactly one per cycle
  a_r2_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr4_mr_image.sv
module ddr4_mr_image
  import ddr4_init_pkg::*;
(
  input  mr_fields_t       f,
  input  logic [2:0]       mr_sel,
  output logic [MRV_W-1:0] value
);

  always_comb begin
    value = '0;
    case (mr_sel)
      3'd0: begin
        value[6:4] = f.cl[3:1];
        value[2]   = f.cl[0];
      end
      3'd1: begin
        value[0]    = 1'b1;
        value[2:1]  = f.drv;
        value[10:8] = f.rtt_nom;
      end
      3'd2: begin
        value[5:3]  = f.cwl;
        value[11:9] = f.rtt_wr;
      end
      3'd5: value[8:6] = f.rtt_park;
      3'd6: begin
        value[5:0] = f.vref;
        value[6]   = f.vref_rng;
      end
      default: value = '0;
    endcase
  end

endmodule

// File: rtl/ddr4_init_fsm.sv
module ddr4_init_fsm
  import ddr4_init_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  t_reset,
  input  logic [CNT_W-1:0]  t_cke,
  input  logic [CNT_W-1:0]  t_xpr,
  input  logic [CNT_W-1:0]  t_mrd,
  input  logic [CNT_W-1:0]  t_zqinit,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output st_e               st_q,
  output logic [STEP_W-1:0] step_q
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_MRS - 1);
  localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0]  TWO       = CNT_W'(2);

  st_e               st_d;
  logic [STEP_W-1:0] step_d;
  logic              last;

  // Phase length floor of one cycle; counter loads length minus one.
  function automatic logic [CNT_W-1:0] len_m1(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  assign last = (step_q == LAST_STEP);

  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st_q)
      ST_OFF, ST_IDLE: if (start) begin
        st_d     = ST_RST;
        step_d   = '0;
        tmr_load = 1'b1;
        tmr_val  = len_m1(t_reset);
      end
      ST_RST: if (tmr_zero) begin
        st_d     = ST_CKE;
        tmr_load = 1'b1;
        tmr_val  = len_m1(t_cke);
      end
      ST_CKE: if (tmr_zero) begin
        st_d     = ST_XPR;
        tmr_load = 1'b1;
        tmr_val  = len_m1(t_xpr);
      end
      ST_XPR: if (tmr_zero) begin
        st_d   = ST_MRS;
        step_d = '0;
      end
      ST_MRS: begin
        if (t_mrd > ONE) begin
          st_d     = ST_GAP;
          tmr_load = 1'b1;
          tmr_val  = t_mrd - TWO;
        end else if (last) begin
          st_d = ST_ZQ;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_GAP: if (tmr_zero) begin
        if (last) st_d = ST_ZQ;
        else begin
          st_d   = ST_MRS;
          step_d = step_q + 1'b1;
        end
      end
      ST_ZQ: begin
        if (t_zqinit > ONE) begin
          st_d     = ST_ZQW;
          tmr_load = 1'b1;
          tmr_val  = t_zqinit - TWO;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_ZQW: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      step_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
    end
  end

  // R9: no busy state ever falls back into reset hold
  a_r9_busy_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q inside {ST_CKE, ST_XPR, ST_MRS, ST_GAP, ST_ZQ, ST_ZQW}) |=> (st_q != ST_RST));

  // R5: two back-to-back loads step through the order by one
  a_r5_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MRS && $past(st_q) == ST_MRS) |-> (step_q == $past(step_q) + 1'b1));

  // R8: the done state is left only on a start
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/ddr4_init_seq.sv
module ddr4_init_seq
  import ddr4_init_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] t_reset,
  input  logic [CNT_W-1:0] t_cke,
  input  logic [CNT_W-1:0] t_xpr,
  input  logic [CNT_W-1:0] t_mrd,
  input  logic [CNT_W-1:0] t_zqinit,
  input  logic [1:0]       drv_str,
  input  logic [2:0]       rtt_nom,
  input  logic [2:0]       rtt_wr,
  input  logic [2:0]       rtt_park,
  input  logic [5:0]       vref_val,
  input  logic             vref_rng,
  input  logic [3:0]       cas_lat,
  input  logic [2:0]       cas_wr_lat,
  output logic             dram_reset_n,
  output logic             dram_cke,
  output logic             cmd_valid,
  output logic [1:0]       cmd_type,
  output logic [2:0]       cmd_mr,
  output logic [16:0]      cmd_value,
  output logic             init_done
);

  st_e               st_q;
  logic [STEP_W-1:0] step_q;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  mr_fields_t        fields;
  logic [2:0]        mr_sel;
  logic [MRV_W-1:0]  image;

  assign fields = '{drv: drv_str, rtt_nom: rtt_nom, rtt_wr: rtt_wr, rtt_park: rtt_park,
                    vref: vref_val, vref_rng: vref_rng, cl: cas_lat, cwl: cas_wr_lat};

  ddr4_init_fsm #(.CNT_W(CNT_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .t_reset(t_reset), .t_cke(t_cke), .t_xpr(t_xpr), .t_mrd(t_mrd), .t_zqinit(t_zqinit),
    .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .st_q(st_q), .step_q(step_q)
  );

  ddr4_init_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  assign mr_sel = mr_at_step(step_q);

  ddr4_mr_image img_i (.f(fields), .mr_sel(mr_sel), .value(image));

  always_comb begin
    dram_reset_n = !(st_q inside {ST_OFF, ST_RST});
    dram_cke     = st_q inside {ST_XPR, ST_MRS, ST_GAP, ST_ZQ, ST_ZQW, ST_IDLE};
    init_done    = (st_q == ST_IDLE);
    cmd_valid    = 1'b0;
    cmd_type     = CMD_NOP;
    cmd_mr       = '0;
    cmd_value    = '0;
    if (st_q == ST_MRS) begin
      cmd_valid = 1'b1;
      cmd_type  = CMD_MRS;
      cmd_mr    = mr_sel;
      cmd_value = image;
    end else if (st_q == ST_ZQ) begin
      cmd_valid = 1'b1;
      cmd_type  = CMD_ZQCL;
    end
  end

  // R3: clock enable only with reset released
  a_r3_cke_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
    dram_cke |-> dram_reset_n);

  // R6: commands only reach a device that is clocked and out of reset
  a_r6_cmd_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (dram_cke && dram_reset_n));

  // R8: nothing is issued once done
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !cmd_valid);

  // R10: a start in done state drops reset and clock enable at once
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && start) |=> (!dram_reset_n && !dram_cke && !init_done));

endmodule

// File: tb/ddr4_init_seq_tb.sv
module ddr4_init_seq_tb_top;

  localparam int CNT_W = 16;
  localparam int MAXC  = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] t_reset = '0, t_cke = '0, t_xpr = '0, t_mrd = '0, t_zqinit = '0;
  logic [1:0] drv_str = '0;
  logic [2:0] rtt_nom = '0, rtt_wr = '0, rtt_park = '0, cas_wr_lat = '0;
  logic [5:0] vref_val = '0;
  logic       vref_rng = 1'b0;
  logic [3:0] cas_lat = '0;
  logic dram_reset_n, dram_cke, cmd_valid, init_done;
  logic [1:0] cmd_type;
  logic [2:0] cmd_mr;
  logic [16:0] cmd_value;

  always #5 clk = ~clk;

  ddr4_init_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .t_reset(t_reset), .t_cke(t_cke), .t_xpr(t_xpr), .t_mrd(t_mrd), .t_zqinit(t_zqinit),
    .drv_str(drv_str), .rtt_nom(rtt_nom), .rtt_wr(rtt_wr), .rtt_park(rtt_park),
    .vref_val(vref_val), .vref_rng(vref_rng), .cas_lat(cas_lat), .cas_wr_lat(cas_wr_lat),
    .dram_reset_n(dram_reset_n), .dram_cke(dram_cke), .cmd_valid(cmd_valid),
    .cmd_type(cmd_type), .cmd_mr(cmd_mr), .cmd_value(cmd_value), .init_done(init_done)
  );

  int nchk = 0, nerr = 0;
  int pc = 0;

  always @(posedge clk) pc <= pc + 1;

  // Monitor: records edges and commands, sampled at the falling edge.
  int   mon_n = 0;
  int   c_t[MAXC];
  int   c_type[MAXC];
  int   c_mr[MAXC];
  int   c_val[MAXC];
  int   t_rst_rise = -1, t_cke_rise = -1, t_done_rise = -1;
  int   idle_bad = 0, done_cmd = 0;
  logic p_rst = 1'b0, p_cke = 1'b0, p_done = 1'b0;

  always @(negedge clk) begin
    if (dram_reset_n && !p_rst) t_rst_rise = pc;
    if (dram_cke && !p_cke)     t_cke_rise = pc;
    if (init_done && !p_done)   t_done_rise = pc;
    if (cmd_valid) begin
      if (mon_n < MAXC) begin
        c_t[mon_n]    = pc;
        c_type[mon_n] = int'(cmd_type);
        c_mr[mon_n]   = int'(cmd_mr);
        c_val[mon_n]  = int'(cmd_value);
      end
      mon_n = mon_n + 1;
      if (init_done) done_cmd = done_cmd + 1;
    end else if (cmd_value != '0 || cmd_type != 2'd0) begin
      idle_bad = idle_bad + 1;
    end
    p_rst  = dram_reset_n;
    p_cke  = dram_cke;
    p_done = init_done;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int flr(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int exp_mr(input int step);
    int order[7] = '{3, 6, 5, 4, 2, 1, 0};
    return order[step];
  endfunction

  function automatic int exp_val(input int mr);
    int v = 0;
    case (mr)
      0: v = (int'(cas_lat[3:1]) << 4) | (int'(cas_lat[0]) << 2);
      1: v = 1 | (int'(drv_str) << 1) | (int'(rtt_nom) << 8);
      2: v = (int'(cas_wr_lat) << 3) | (int'(rtt_wr) << 9);
      5: v = int'(rtt_park) << 6;
      6: v = int'(vref_val) | (int'(vref_rng) << 6);
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic set_cfg(input int tr, input int tc, input int tx, input int tm, input int tz);
    t_reset = CNT_W'(tr); t_cke = CNT_W'(tc); t_xpr = CNT_W'(tx);
    t_mrd = CNT_W'(tm); t_zqinit = CNT_W'(tz);
    drv_str = 2'($urandom); rtt_nom = 3'($urandom); rtt_wr = 3'($urandom);
    rtt_park = 3'($urandom); vref_val = 6'($urandom); vref_rng = 1'($urandom);
    cas_lat = 4'($urandom); cas_wr_lat = 3'($urandom);
  endtask

  // One full sequence; poke_busy injects a start while the sequence runs.
  task automatic run_seq(input bit poke_busy);
    int t_acc, base, lr, lc, lx, lm, lz, guard;
    bit from_done;
    from_done = init_done;
    @(negedge clk);
    start = 1'b1;
    t_acc = pc + 1;
    base  = mon_n;
    @(negedge clk);
    start = 1'b0;
    if (from_done) begin
      chk("R10 done falls on restart", int'(init_done), 0);
      chk("R10 reset low on restart", int'(dram_reset_n), 0);
      chk("R10 cke low on restart", int'(dram_cke), 0);
    end
    lr = flr(int'(t_reset)); lc = flr(int'(t_cke)); lx = flr(int'(t_xpr));
    lm = flr(int'(t_mrd));   lz = flr(int'(t_zqinit));
    if (poke_busy) begin
      while (pc < t_acc + lr) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!init_done && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    chk("R2 reset hold length", t_rst_rise - t_acc, lr);
    chk("R3 cke delay", t_cke_rise - t_rst_rise, lc);
    chk("R3 cke still high", int'(dram_cke), 1);
    chk("R6 command count", mon_n - base, 8);
    if (mon_n - base == 8 && mon_n <= MAXC) begin
      chk("R4 first load delay", c_t[base] - t_cke_rise, lx);
      for (int i = 0; i < 7; i++) begin
        chk("R5 load type", c_type[base+i], 1);
        chk("R5 load order", c_mr[base+i], exp_mr(i));
        chk("R7 register image", c_val[base+i], exp_val(exp_mr(i)));
        chk("R6 command spacing", c_t[base+i+1] - c_t[base+i], lm);
      end
      chk("R8 zq type", c_type[base+7], 2);
      chk("R8 zq register field", c_mr[base+7], 0);
      chk("R8 zq value", c_val[base+7], 0);
      chk("R8 done delay", t_done_rise - c_t[base+7], lz);
    end
    chk("R8 done high", int'(init_done), 1);
    if (poke_busy) chk("R9 busy start ignored, reset rose once", t_rst_rise - t_acc, lr);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset_n low", int'(dram_reset_n), 0);
    chk("R1 cke low", int'(dram_cke), 0);
    chk("R1 valid low", int'(cmd_valid), 0);
    chk("R1 done low", int'(init_done), 0);
    chk("R1 value zero", int'(cmd_value), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 still idle before start", int'(dram_reset_n) + int'(dram_cke) + int'(init_done), 0);

    // Directed: all counts zero, then all one (floor and back-to-back path).
    set_cfg(0, 0, 0, 0, 0);
    run_seq(1'b0);
    set_cfg(1, 1, 1, 1, 1);
    run_seq(1'b0);
    // Directed: start pulse during the sequence.
    set_cfg(6, 5, 4, 3, 9);
    run_seq(1'b1);
    // Random runs, each restarting from the done state.
    for (int k = 0; k < 12; k++) begin
      set_cfg(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
              int'($urandom_range(0, 15)), int'($urandom_range(0, 5)),
              int'($urandom_range(0, 40)));
      run_seq(k == 5);
    end
    chk("R6 no value or type outside commands", idle_bad, 0);
    chk("R8 no command while done", done_cmd, 0);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule